// File: doc/BRIEF.md
# Fully Associative LRU Tag Store with Multi-Size Hit Tracking

This block is the tag half of a small fully associative cache that uses true least-recently-used replacement. A single set holds a parameterised number of entries. Each entry has a valid bit and a tag, which is the request address with the in-block offset stripped. The recency of each entry is kept as a rank, from 0 for the most recent entry to N-1 for the least recent. Four operations are defined. An access looks up a tag and refreshes its recency. A probe looks up a tag without touching recency. An insert fills the least recent entry. An invalidate drops an entry and sends it to the least recent end.

Alongside the real cache, the block answers a second question on every access: would this access also have hit in a smaller cache? The tracked sizes are powers of two, from a minimum byte size up to half the real size. A fully associative LRU cache of size S holds exactly the S/block most recent blocks. Each entry's inclusion mask therefore follows from its rank, and one lookup gives a hit or miss verdict for every tracked size. Per-size hit and miss counters and a total access counter sum these verdicts for performance studies.

Every operation finishes in one clock cycle. The response (hit, entry index, inclusion mask) is combinational from the request and the state before the edge. Recency, valid bits, tags and counters update at that edge.

Top module: `falru_tags`

## Requirements
- R1: The tag is `op_addr[ADDR_W-1:OFF_W]` with `OFF_W = log2(BLK_BYTES)`. Two addresses that differ only in offset bits match the same entry.
- R2: After reset every entry is invalid, entry k holds rank k (entry N-1 is least recent), and all counters read zero.
- R3: Access is `op_kind = 0`. On a hit, `rsp_hit` is 1 and `rsp_idx` is the matching entry. After the edge that entry has rank 0, every entry that was more recent moves down one rank, and all others keep their rank. A miss changes no rank.
- R4: Probe is `op_kind = 1`. It returns the same `rsp_hit`, `rsp_idx` and `rsp_mask` as an access would, but it changes no rank and no counter.
- R5: Insert is `op_kind = 2`. In the same cycle, `rsp_idx` shows the entry at rank N-1. At the edge that entry takes the new tag, becomes valid and moves to rank 0, and every other entry moves down one rank.
- R6: Invalidate is `op_kind = 3`. If the tag matches, the entry becomes invalid and moves to rank N-1, and the entries that were less recent move up one rank. Without a match nothing changes.
- R7: On a hit, `rsp_mask` bit i is 1 exactly when the entry's rank is below `(MIN_BYTES << i) / BLK_BYTES`. Bit 0 is the smallest size, and each higher bit is a size twice as large. On a miss the mask is 0.
- R8: `acc_cnt` rises by one after every access and after no other operation.
- R9: Size i owns bits `[i*CNT_W +: CNT_W]` of `hit_cnt` and of `miss_cnt`. An access that misses adds one to every miss counter. An access that hits adds one to the hit counter of each size whose mask bit is 1, and one to the miss counter of each size whose bit is 0.
- R10: The number of tracked sizes is `log2(MAX_BYTES) - log2(MIN_BYTES)`. This is the width of `rsp_mask` and the number of counters per kind. Elaboration rejects configurations where this count is below one or the sizes are not powers of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 0 access, 1 probe, 2 insert, 3 invalidate |
| op_addr | input | ADDR_W | Byte address of the operation |
| rsp_hit | output | 1 | The tag matches a valid entry |
| rsp_idx | output | IDX_W | Matching entry, or the fill victim on insert |
| rsp_mask | output | NSZ | Tracked sizes that contain the matching entry |
| acc_cnt | output | CNT_W | Total accesses |
| hit_cnt | output | NSZ*CNT_W | Per-size hit counters |
| miss_cnt | output | NSZ*CNT_W | Per-size miss counters |

## Verification
The hardest situation to reach from the ports is a hit on an entry that sits exactly at a size boundary, after an invalidate has reshuffled the ranks. It needs a full store, reuse at every depth, and holes that later inserts refill. The bench first fills all entries and sweeps accesses across every depth. It then runs a long pseudo-random mix over a tag pool slightly larger than the store. Inserts of tags that are already present are turned into accesses, so hits, evictions and invalidations interleave. Every response and every counter is compared with an ordered-list model after each operation.

// File: rtl/falru_pkg.sv
package falru_pkg;
   typedef enum logic [1:0] {
      OP_ACCESS = 2'd0,
      OP_PROBE  = 2'd1,
      OP_INSERT = 2'd2,
      OP_INVAL  = 2'd3
   } falru_op_e;
endpackage

// File: rtl/falru_match.sv
module falru_match #(
   parameter int N     = 8,
   parameter int TAG_W = 28,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0][TAG_W-1:0] tags,
   input  logic [N-1:0]            valid,
   input  logic [TAG_W-1:0]        key,
   output logic                    hit,
   output logic [IDX_W-1:0]        idx
);
   logic [N-1:0] eq;

   for (genvar e = 0; e < N; e++) begin : g_cmp
      assign eq[e] = valid[e] && (tags[e] == key);
   end

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int e = 0; e < N; e++) begin
         if (eq[e] && !hit) begin
            hit = 1'b1;
            idx = IDX_W'(e);
         end
      end
   end
endmodule

// File: rtl/falru_order.sv
module falru_order #(
   parameter int N = 8,
   localparam int PW = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            upd_en,
   input  logic            upd_demote,
   input  logic [PW-1:0]   upd_sel,
   output logic [N*PW-1:0] pos_flat,
   output logic [PW-1:0]   lru_idx
);
   logic [PW-1:0] pos_q [N];
   logic [PW-1:0] sel_pos;

   assign sel_pos = pos_q[upd_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < N; e++) pos_q[e] <= PW'(e);
      end else if (upd_en) begin
         for (int e = 0; e < N; e++) begin
            if (upd_demote) begin
               if (PW'(e) == upd_sel)     pos_q[e] <= PW'(N - 1);
               else if (pos_q[e] > sel_pos) pos_q[e] <= pos_q[e] - 1'b1;
            end else begin
               if (PW'(e) == upd_sel)     pos_q[e] <= '0;
               else if (pos_q[e] < sel_pos) pos_q[e] <= pos_q[e] + 1'b1;
            end
         end
      end
   end

   for (genvar e = 0; e < N; e++) begin : g_flat
      assign pos_flat[e*PW +: PW] = pos_q[e];
   end

   always_comb begin
      lru_idx = '0;
      for (int e = 0; e < N; e++) begin
         if (pos_q[e] == PW'(N - 1)) lru_idx = PW'(e);
      end
   end
endmodule

// File: rtl/falru_stats.sv
module falru_stats #(
   parameter int NSZ   = 3,
   parameter int CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_en,
   input  logic               hit,
   input  logic [NSZ-1:0]     mask,
   output logic [CNT_W-1:0]   acc_cnt,
   output logic [NSZ*CNT_W-1:0] hit_cnt,
   output logic [NSZ*CNT_W-1:0] miss_cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_cnt <= '0;
      else if (acc_en) acc_cnt <= acc_cnt + 1'b1;
   end

   for (genvar i = 0; i < NSZ; i++) begin : g_size
      logic [CNT_W-1:0] h_q, m_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            h_q <= '0;
            m_q <= '0;
         end else if (acc_en) begin
            if (hit && mask[i]) h_q <= h_q + 1'b1;
            else                m_q <= m_q + 1'b1;
         end
      end
      assign hit_cnt[i*CNT_W +: CNT_W]  = h_q;
      assign miss_cnt[i*CNT_W +: CNT_W] = m_q;
   end
endmodule

// File: rtl/falru_tags.sv
module falru_tags
   import falru_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLK_BYTES   = 16,
   parameter int NUM_ENTRIES = 8,
   parameter int MIN_BYTES   = 16,
   parameter int MAX_BYTES   = 128,
   parameter int CNT_W       = 16,
   localparam int OFF_W = $clog2(BLK_BYTES),
   localparam int TAG_W = ADDR_W - OFF_W,
   localparam int IDX_W = $clog2(NUM_ENTRIES),
   localparam int NSZ   = $clog2(MAX_BYTES) - $clog2(MIN_BYTES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [1:0]           op_kind,
   input  logic [ADDR_W-1:0]    op_addr,
   output logic                 rsp_hit,
   output logic [IDX_W-1:0]     rsp_idx,
   output logic [NSZ-1:0]       rsp_mask,
   output logic [CNT_W-1:0]     acc_cnt,
   output logic [NSZ*CNT_W-1:0] hit_cnt,
   output logic [NSZ*CNT_W-1:0] miss_cnt
);
   // Elaboration-time parameter checks
   if (NSZ < 1) begin : g_bad_nsz
      $error("falru_tags: MAX_BYTES must exceed MIN_BYTES");
   end
   if ((1 << $clog2(MIN_BYTES)) != MIN_BYTES || (1 << $clog2(MAX_BYTES)) != MAX_BYTES
       || (1 << OFF_W) != BLK_BYTES) begin : g_bad_pow2
      $error("falru_tags: sizes must be powers of two");
   end
   if (MIN_BYTES < BLK_BYTES || NUM_ENTRIES < 2) begin : g_bad_geom
      $error("falru_tags: smallest size below one block or too few entries");
   end

   falru_op_e                          kind;
   logic [TAG_W-1:0]                   key;
   logic [NUM_ENTRIES-1:0][TAG_W-1:0]  tag_q;
   logic [NUM_ENTRIES-1:0]             valid_q;
   logic                               m_hit;
   logic [IDX_W-1:0]                   m_idx, lru_idx, upd_sel;
   logic [NUM_ENTRIES*IDX_W-1:0]       pos_flat;
   logic [NSZ-1:0]                     ent_mask [NUM_ENTRIES];
   logic                               do_acc, do_ins, do_inv, upd_en;
   logic                               unused_offset;

   assign kind          = falru_op_e'(op_kind);
   assign key           = op_addr[ADDR_W-1:OFF_W];
   assign unused_offset = ^op_addr[OFF_W-1:0];

   falru_match #(.N(NUM_ENTRIES), .TAG_W(TAG_W)) u_match (
      .tags(tag_q), .valid(valid_q), .key(key), .hit(m_hit), .idx(m_idx)
   );

   assign do_acc  = op_valid && (kind == OP_ACCESS);
   assign do_ins  = op_valid && (kind == OP_INSERT);
   assign do_inv  = op_valid && (kind == OP_INVAL) && m_hit;
   assign upd_en  = (do_acc && m_hit) || do_ins || do_inv;
   assign upd_sel = do_ins ? lru_idx : m_idx;

   falru_order #(.N(NUM_ENTRIES)) u_order (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_demote(do_inv),
      .upd_sel(upd_sel), .pos_flat(pos_flat), .lru_idx(lru_idx)
   );

   // Inclusion mask: size i holds the (MIN_BYTES<<i)/BLK_BYTES most recent blocks
   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      for (genvar i = 0; i < NSZ; i++) begin : g_sz
         localparam logic [31:0] THR = 32'((MIN_BYTES << i) / BLK_BYTES);
         assign ent_mask[e][i] = 32'(pos_flat[e*IDX_W +: IDX_W]) < THR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q <= '0;
      else if (do_ins) valid_q[lru_idx] <= 1'b1;
      else if (do_inv) valid_q[m_idx]   <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (do_ins) tag_q[lru_idx] <= key;
   end

   assign rsp_hit  = m_hit;
   assign rsp_idx  = (kind == OP_INSERT) ? lru_idx : m_idx;
   assign rsp_mask = m_hit ? ent_mask[m_idx] : '0;

   falru_stats #(.NSZ(NSZ), .CNT_W(CNT_W)) u_stats (
      .clk(clk), .rst_n(rst_n), .acc_en(do_acc), .hit(m_hit), .mask(rsp_mask),
      .acc_cnt(acc_cnt), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
   );
endmodule

// File: rtl/falru_chk.sv
module falru_chk #(
   parameter int N     = 8,
   parameter int IDX_W = 3,
   parameter int NSZ   = 3,
   parameter int CNT_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic [1:0]           op_kind,
   input logic                 rsp_hit,
   input logic [IDX_W-1:0]     rsp_idx,
   input logic [NSZ-1:0]       rsp_mask,
   input logic [N*IDX_W-1:0]   pos_flat,
   input logic [N-1:0]         valid_q,
   input logic [CNT_W-1:0]     acc_cnt,
   input logic [NSZ*CNT_W-1:0] miss_cnt
);
   localparam logic [NSZ-1:0] TOP = NSZ'(1) << (NSZ - 1);
   logic [IDX_W-1:0] pos_arr [N];
   logic [N-1:0]     at_mru, at_lru;

   for (genvar e = 0; e < N; e++) begin : g_p
      assign pos_arr[e] = pos_flat[e*IDX_W +: IDX_W];
      assign at_mru[e]  = pos_arr[e] == '0;
      assign at_lru[e]  = pos_arr[e] == IDX_W'(N - 1);
   end

   AST_ONE_MRU: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(at_mru) == 1); // R3
   AST_ONE_LRU: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(at_lru) == 1); // R5
   AST_ACCESS_PROMOTES: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == 2'd0 && rsp_hit |=> pos_arr[$past(rsp_idx)] == '0); // R3
   AST_PROBE_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == 2'd1 |=> $stable(pos_flat) && $stable(acc_cnt)); // R4
   AST_INSERT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == 2'd2 |=> valid_q[$past(rsp_idx)] && pos_arr[$past(rsp_idx)] == '0); // R5
   AST_INVAL_DEMOTES: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == 2'd3 && rsp_hit |=>
         !valid_q[$past(rsp_idx)] && pos_arr[$past(rsp_idx)] == IDX_W'(N - 1)); // R6
   AST_MASK_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_mask & ~(rsp_mask >> 1) & ~TOP) == '0); // R7
   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == 2'd0 |=> acc_cnt == $past(acc_cnt) + 1'b1); // R8
   AST_MISS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_kind == 2'd0 && !rsp_hit |=>
         miss_cnt[CNT_W-1:0] == $past(miss_cnt[CNT_W-1:0]) + 1'b1); // R9
endmodule

bind falru_tags falru_chk #(
   .N(NUM_ENTRIES), .IDX_W(IDX_W), .NSZ(NSZ), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
   .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_mask(rsp_mask),
   .pos_flat(pos_flat), .valid_q(valid_q), .acc_cnt(acc_cnt), .miss_cnt(miss_cnt)
);

// File: tb/tb_falru_tags.sv
`timescale 1ns/100ps
module tb_falru_tags;
   localparam int ADDR_W = 32, BLK = 16, N = 8, MINB = 16, MAXB = 128, CW = 16;
   localparam int OFF_W = 4, TAG_W = ADDR_W - OFF_W, IDX_W = 3;
   localparam int NSZ = 3;  // log2(128) - log2(16)

   logic clk = 1'b0, rst_n = 1'b0;
   logic op_valid = 1'b0;
   logic [1:0] op_kind = 2'd0;
   logic [ADDR_W-1:0] op_addr = '0;
   logic rsp_hit;
   logic [IDX_W-1:0] rsp_idx;
   logic [NSZ-1:0] rsp_mask;
   logic [CW-1:0] acc_cnt;
   logic [NSZ*CW-1:0] hit_cnt, miss_cnt;

   always #2.5 clk = ~clk;

   falru_tags #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK), .NUM_ENTRIES(N), .MIN_BYTES(MINB),
                .MAX_BYTES(MAXB), .CNT_W(CW)) dut (.*);

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   // Ordered-list model, index 0 = most recent
   int m_idx [N];
   logic [TAG_W-1:0] m_tag [N];
   bit m_val [N];
   int e_acc = 0;
   int e_hit [NSZ];
   int e_miss [NSZ];
   logic [31:0] seed = 32'h1234_5678;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic check_counters(input string req);
      chk(acc_cnt == CW'(e_acc), "R8", acc_cnt, e_acc);
      for (int i = 0; i < NSZ; i++) begin
         chk(hit_cnt[i*CW +: CW] == CW'(e_hit[i]), req, hit_cnt[i*CW +: CW], e_hit[i]);
         chk(miss_cnt[i*CW +: CW] == CW'(e_miss[i]), req, miss_cnt[i*CW +: CW], e_miss[i]);
      end
   endtask

   function automatic int find_pos(input logic [TAG_W-1:0] t);
      for (int p = 0; p < N; p++) if (m_val[p] && m_tag[p] == t) return p;
      return -1;
   endfunction

   function automatic void promote(input int p);
      int id = m_idx[p]; logic [TAG_W-1:0] t = m_tag[p]; bit v = m_val[p];
      for (int q = p; q > 0; q--) begin
         m_idx[q] = m_idx[q-1]; m_tag[q] = m_tag[q-1]; m_val[q] = m_val[q-1];
      end
      m_idx[0] = id; m_tag[0] = t; m_val[0] = v;
   endfunction

   function automatic void demote(input int p);
      int id = m_idx[p]; logic [TAG_W-1:0] t = m_tag[p];
      for (int q = p; q < N - 1; q++) begin
         m_idx[q] = m_idx[q+1]; m_tag[q] = m_tag[q+1]; m_val[q] = m_val[q+1];
      end
      m_idx[N-1] = id; m_tag[N-1] = t; m_val[N-1] = 1'b0;
   endfunction

   function automatic logic [NSZ-1:0] exp_mask(input int p);
      logic [NSZ-1:0] m = '0;
      for (int i = 0; i < NSZ; i++) m[i] = (p >= 0) && (p < ((MINB << i) / BLK));
      return m;
   endfunction

   task automatic run_op(input int kind, input logic [TAG_W-1:0] t, input logic [OFF_W-1:0] off,
                         input string req);
      int p;
      logic [NSZ-1:0] em;
      @(negedge clk);
      op_valid = 1'b1; op_kind = 2'(kind); op_addr = {t, off};
      p = find_pos(t);
      em = exp_mask(p);
      #1;
      if (kind != 2) begin
         chk(rsp_hit == (p >= 0), req, rsp_hit, p >= 0);
         if (p >= 0) chk(rsp_idx == IDX_W'(m_idx[p]), req, rsp_idx, m_idx[p]);
         chk(rsp_mask == em, "R7", rsp_mask, em);
      end else begin
         chk(rsp_idx == IDX_W'(m_idx[N-1]), "R5", rsp_idx, m_idx[N-1]);
      end
      case (kind)
         0: begin
            e_acc++;
            for (int i = 0; i < NSZ; i++) if (p >= 0 && em[i]) e_hit[i]++; else e_miss[i]++;
            if (p >= 0) promote(p);
         end
         2: begin
            m_tag[N-1] = t; m_val[N-1] = 1'b1; promote(N - 1);
         end
         3: if (p >= 0) demote(p);
         default: ;
      endcase
      @(posedge clk); #1;
      check_counters(kind == 0 ? "R9" : "R4");
      op_valid = 1'b0;
   endtask

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 8;
   endfunction

   initial begin
      for (int p = 0; p < N; p++) begin m_idx[p] = p; m_tag[p] = '0; m_val[p] = 0; end
      for (int i = 0; i < NSZ; i++) begin e_hit[i] = 0; e_miss[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R2: reset state
      check_counters("R2");
      chk($bits(rsp_mask) == NSZ, "R10", $bits(rsp_mask), NSZ);
      run_op(1, 28'h5, 4'h0, "R2");           // empty store probe misses
      run_op(0, 28'h5, 4'h3, "R2");           // access miss on empty store
      // Fill with inserts; victim order follows the reset ranks
      for (int k = 0; k < N; k++) run_op(2, TAG_W'(100 + k), OFF_W'(k), "R5");
      // R1: different offsets hit the same entry, sweeping every depth
      for (int k = 0; k < N; k++) run_op(0, TAG_W'(100 + k), OFF_W'(15 - k), "R1");
      for (int k = 0; k < N; k++) run_op(1, TAG_W'(100 + k), OFF_W'(k), "R4");
      run_op(3, 28'h999, 4'h0, "R6");         // invalidate miss: no change
      run_op(3, TAG_W'(103), 4'h1, "R6");
      run_op(0, TAG_W'(103), 4'h1, "R6");     // must now miss
      run_op(2, TAG_W'(200), 4'h2, "R5");     // refills the invalidated entry
      // Pseudo-random mix over a pool slightly larger than the store
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r = rnd();
         int sel = int'(r[3:0]) % 10;
         logic [TAG_W-1:0] t = TAG_W'(300 + (int'(r[11:4]) % 11));
         logic [OFF_W-1:0] off = r[15:12];
         if (sel < 5) run_op(0, t, off, "R3");
         else if (sel == 5) run_op(1, t, off, "R4");
         else if (sel < 9) begin
            if (find_pos(t) >= 0) run_op(0, t, off, "R3");
            else run_op(2, t, off, "R5");
         end else run_op(3, t, off, "R6");
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule